// File: doc/BRIEF.md
# Interrupt Gate Entry Sequencer

This block carries out the memory side of entering an interrupt or exception handler. It accepts a request holding an 8-bit vector, a flag that says whether the event has an error code, the error code, and a snapshot of the current execution state. The state is made of the privilege ring, code selector, instruction pointer, flags, stack selector and stack pointer. It fetches the 8-byte gate entry for the vector from a gate table, classifies the gate, and finds the target ring. When the target ring is more privileged than the current one, it fetches a fresh stack from a per-ring stack table. It then writes the handler frame onto the chosen stack one 32-bit word per accepted write.

When the sequence ends, the block pulses `done` together with a status code and the execution state that the handler starts with. Task gates, 16-bit gates, undecodable types and gates that would lower privilege are not handled. Each of these ends at once with its own status and performs no write. Both tables sit behind a single read port that returns data one cycle after the read strobe.

Top module: `igate_seq`

## Requirements
- R1: After reset and whenever `busy` is low, `rd_en`, `wr_valid` and `done` are low. A request is taken only in a cycle where `busy` is low. `req_valid` is ignored while `busy` is high, including the cycle of `done`.
- R2: The gate entry is read from address GATE_BASE + 8 × vector. Its offset is bits 63:48 (high half) and 15:0 (low half), its code selector is bits 31:16, and its type is bits 43:40.
- R3: Type 1110 is a 32-bit interrupt gate and type 1111 is a 32-bit trap gate. Type 0101 ends with status 1 (task gate). Types 0110 and 0111 end with status 3 (16-bit gate, unsupported). Every other type ends with status 2 (invalid). None of these three outcomes performs any write.
- R4: The target ring is bits 1:0 of the gate selector. A target ring numerically greater than the current ring ends with status 2 and performs no write.
- R5: When the target ring equals the current ring, no stack table read is made, and the frame is pushed onto the current stack.
- R6: When the target ring is lower than the current ring, the stack entry is read from STACK_BASE + 8 × target ring, with the pointer in bits 31:0 and the selector in bits 47:32. The old stack selector (zero-extended) is pushed first, then the old stack pointer.
- R7: The next words pushed are the old flags, the old code selector (zero-extended) and the old instruction pointer. When the request has an error code, that code is pushed last.
- R8: Each push writes to the stack pointer minus 4, and the pointer then moves down by 4. The address and data are held while `wr_ready` is low. At most one word is accepted per cycle.
- R9: `done` is a one-cycle pulse. On status 0, it comes with the new ring (the target ring), code selector (the gate selector), instruction pointer (the gate offset), stack selector, and the stack pointer left after the last push.
- R10: Entry through an interrupt gate clears flag bit 9 in `new_flags`. Entry through a trap gate returns the old flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Entry request, taken when not busy |
| req_vector | input | 8 | Vector number |
| req_has_err | input | 1 | Event carries an error code |
| req_err | input | 32 | Error code |
| cur_ring | input | 2 | Current privilege ring |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Current instruction pointer |
| cur_flags | input | 32 | Current flags |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| busy | output | 1 | A request is in progress |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | 32 | Table read byte address |
| rd_data | input | 64 | Read data, valid the cycle after `rd_en` |
| wr_valid | output | 1 | Stack write offered |
| wr_ready | input | 1 | Stack write accepted |
| wr_addr | output | 32 | Stack write byte address |
| wr_data | output | 32 | Stack write word |
| done | output | 1 | End-of-sequence pulse |
| status | output | 2 | 0 ok, 1 task gate, 2 invalid, 3 unsupported |
| new_ring | output | 2 | Handler ring |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 32 | Handler instruction pointer |
| new_flags | output | 32 | Handler flags |
| new_ss | output | 16 | Handler stack selector |
| new_sp | output | 32 | Handler stack pointer |

## Verification
Two events can meet in one cycle. The first is the completion pulse. The second is a fresh request, which can also arrive during a stalled final push. The bench holds `req_valid` high for an entire entry, switches its vector partway through, and lowers it only in the cycle where `done` is seen. It then judges that exactly one result, one gate read and the expected pushes appeared, and that nothing followed them. Write back-pressure runs from a repeating ready pattern, so stalls land on first, middle and last pushes, and the scoreboard compares every accepted address and word in order.

// File: rtl/igate_pkg.sv
package igate_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 16;
    localparam int VEC_W  = 8;
    localparam int RING_W = 2;
    localparam int DESC_W = 64;
    localparam int IDX_W  = 3;
    localparam int ENTRY_SHIFT = 3;   // 8-byte table entries

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_TASK  = 2'd1,
        ST_BAD   = 2'd2,
        ST_UNSUP = 2'd3
    } entry_status_e;

    typedef enum logic [2:0] {
        GK_INTR,
        GK_TRAP,
        GK_TASK,
        GK_NARROW,
        GK_BAD
    } gate_kind_e;

    typedef struct packed {
        logic [RING_W-1:0] ring;
        logic [SEL_W-1:0]  cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] flags;
        logic [SEL_W-1:0]  ss;
        logic [WORD_W-1:0] sp;
    } exec_state_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [WORD_W-1:0] offset;
        gate_kind_e        kind;
    } gate_info_t;

    function automatic gate_kind_e classify(input logic [3:0] t);
        case (t)
            4'b1110:         return GK_INTR;
            4'b1111:         return GK_TRAP;
            4'b0101:         return GK_TASK;
            4'b0110,
            4'b0111:         return GK_NARROW;
            default:         return GK_BAD;
        endcase
    endfunction

endpackage

// File: rtl/igate_decode.sv
module igate_decode
    import igate_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [RING_W-1:0] cur_ring,
    output gate_info_t        info,
    output logic              need_switch,
    output entry_status_e     verdict
);
    logic [RING_W-1:0] tgt;

    always_comb begin
        info.sel    = desc[31:16];
        info.offset = {desc[63:48], desc[15:0]};
        info.kind   = classify(desc[43:40]);
        tgt         = desc[16 +: RING_W];
        need_switch = (tgt < cur_ring);
        case (info.kind)
            GK_TASK:   verdict = ST_TASK;
            GK_NARROW: verdict = ST_UNSUP;
            GK_BAD:    verdict = ST_BAD;
            default:   verdict = (tgt > cur_ring) ? ST_BAD : ST_OK;
        endcase
    end
endmodule

// File: rtl/igate_frame.sv
module igate_frame
    import igate_pkg::*;
(
    input  logic              switched,
    input  logic              has_err,
    input  exec_state_t       old,
    input  logic [WORD_W-1:0] err,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word,
    output logic              last
);
    localparam int PAD = WORD_W - SEL_W;

    logic [IDX_W-1:0] slot;
    logic [IDX_W-1:0] count;

    always_comb begin
        count = IDX_W'(3) + (switched ? IDX_W'(2) : IDX_W'(0))
              + (has_err ? IDX_W'(1) : IDX_W'(0));
        slot  = switched ? idx : idx + IDX_W'(2);
        last  = (idx == count - IDX_W'(1));
        case (slot)
            IDX_W'(0): word = {{PAD{1'b0}}, old.ss};
            IDX_W'(1): word = old.sp;
            IDX_W'(2): word = old.flags;
            IDX_W'(3): word = {{PAD{1'b0}}, old.cs};
            IDX_W'(4): word = old.ip;
            default:   word = err;
        endcase
    end
endmodule

// File: rtl/igate_seq.sv
module igate_seq
    import igate_pkg::*;
#(
    parameter logic [31:0] GATE_BASE  = 32'h0000_1000,
    parameter logic [31:0] STACK_BASE = 32'h0000_0800,
    parameter int          IF_BIT     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_has_err,
    input  logic [WORD_W-1:0] req_err,
    input  logic [RING_W-1:0] cur_ring,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0] cur_sp,
    output logic              busy,
    output logic              rd_en,
    output logic [WORD_W-1:0] rd_addr,
    input  logic [DESC_W-1:0] rd_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic [1:0]        status,
    output logic [RING_W-1:0] new_ring,
    output logic [SEL_W-1:0]  new_cs,
    output logic [WORD_W-1:0] new_ip,
    output logic [WORD_W-1:0] new_flags,
    output logic [SEL_W-1:0]  new_ss,
    output logic [WORD_W-1:0] new_sp
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    typedef enum logic [2:0] {
        S_IDLE, S_GREQ, S_GDAT, S_SREQ, S_SDAT, S_PUSH, S_FIN
    } seq_state_e;

    seq_state_e        state;
    exec_state_t       old_q;
    logic [VEC_W-1:0]  vec_q;
    logic              herr_q;
    logic [WORD_W-1:0] err_q;
    gate_info_t        info_q;
    logic              switch_q;
    entry_status_e     status_q;
    logic [SEL_W-1:0]  ss_cur;
    logic [WORD_W-1:0] sp_cur;
    logic [IDX_W-1:0]  idx;

    gate_info_t        dec_info;
    logic              dec_switch;
    entry_status_e     dec_verdict;
    logic [WORD_W-1:0] fw_word;
    logic              fw_last;

    igate_decode u_dec (
        .desc        (rd_data),
        .cur_ring    (old_q.ring),
        .info        (dec_info),
        .need_switch (dec_switch),
        .verdict     (dec_verdict)
    );

    igate_frame u_frame (
        .switched (switch_q),
        .has_err  (herr_q),
        .old      (old_q),
        .err      (err_q),
        .idx      (idx),
        .word     (fw_word),
        .last     (fw_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            old_q    <= '0;
            vec_q    <= '0;
            herr_q   <= 1'b0;
            err_q    <= '0;
            info_q   <= '0;
            switch_q <= 1'b0;
            status_q <= ST_OK;
            ss_cur   <= '0;
            sp_cur   <= '0;
            idx      <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    vec_q  <= req_vector;
                    herr_q <= req_has_err;
                    err_q  <= req_err;
                    old_q  <= '{ring: cur_ring, cs: cur_cs, ip: cur_ip,
                                flags: cur_flags, ss: cur_ss, sp: cur_sp};
                    idx    <= '0;
                    state  <= S_GREQ;
                end
                S_GREQ: state <= S_GDAT;
                S_GDAT: begin
                    info_q   <= dec_info;
                    status_q <= dec_verdict;
                    switch_q <= dec_switch;
                    ss_cur   <= old_q.ss;
                    sp_cur   <= old_q.sp;
                    if (dec_verdict != ST_OK) state <= S_FIN;
                    else if (dec_switch)      state <= S_SREQ;
                    else                      state <= S_PUSH;
                end
                S_SREQ: state <= S_SDAT;
                S_SDAT: begin
                    sp_cur <= rd_data[31:0];
                    ss_cur <= rd_data[47:32];
                    state  <= S_PUSH;
                end
                S_PUSH: if (wr_ready) begin
                    sp_cur <= sp_cur - STEP;
                    idx    <= idx + IDX_W'(1);
                    if (fw_last) state <= S_FIN;
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != S_IDLE);
        rd_en    = (state == S_GREQ) || (state == S_SREQ);
        rd_addr  = (state == S_SREQ)
                 ? STACK_BASE + (WORD_W'(info_q.sel[RING_W-1:0]) << ENTRY_SHIFT)
                 : GATE_BASE + (WORD_W'(vec_q) << ENTRY_SHIFT);
        wr_valid = (state == S_PUSH);
        wr_addr  = sp_cur - STEP;
        wr_data  = fw_word;
        done     = (state == S_FIN);
        status   = status_q;
        new_ring = info_q.sel[RING_W-1:0];
        new_cs   = info_q.sel;
        new_ip   = info_q.offset;
        new_ss   = ss_cur;
        new_sp   = sp_cur;
        new_flags = old_q.flags;
        if (info_q.kind == GK_INTR) new_flags[IF_BIT] = 1'b0;
    end

    // R1: nothing moves on the memory ports while idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_en && !wr_valid && !done));

    // R8: an offered word stays put until taken
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8: consecutive pushes walk down by one word
    a_r8_step: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) - STEP)));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3 / R4: a rejected gate finishes next cycle without writing
    a_r3_reject_no_write: assert property (@(posedge clk) disable iff (rst)
        (state == S_GDAT && dec_verdict != ST_OK) |=> (done && !wr_valid));

    // R10: interrupt-gate entry hands over flags with the enable bit clear
    a_r10_if_clear: assert property (@(posedge clk) disable iff (rst)
        (done && status == ST_OK && info_q.kind == GK_INTR) |-> !new_flags[IF_BIT]);

endmodule

// File: tb/sim_igate_seq.sv
module sim_igate_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GB = 32'h0000_1000;
    localparam logic [31:0] SB = 32'h0000_0800;

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  ring;
        logic [15:0] cs;
        logic [31:0] ip;
        logic [31:0] flags;
        logic [15:0] ss;
        logic [31:0] sp;
    } result_t;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_has_err = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_err = '0, cur_ip = '0, cur_flags = '0, cur_sp = '0;
    logic [1:0]  cur_ring = '0;
    logic [15:0] cur_cs = '0, cur_ss = '0;
    logic busy, rd_en, wr_valid, done;
    logic wr_ready = 1'b1;
    logic [31:0] rd_addr, wr_addr, wr_data, new_ip, new_flags, new_sp;
    logic [63:0] rd_data = '0;
    logic [1:0]  status, new_ring;
    logic [15:0] new_cs, new_ss;

    logic [63:0] gate_tab [256];
    logic [63:0] stk_tab [4];
    logic [63:0] exp_wr [$];
    logic [31:0] exp_rd [$];
    result_t     exp_res [$];
    int checks = 0, fails = 0, n_done = 0, rdy_ctr = 0;
    logic [7:0] rdy_pat = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    igate_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
        .req_has_err(req_has_err), .req_err(req_err), .cur_ring(cur_ring),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_flags(cur_flags), .cur_ss(cur_ss),
        .cur_sp(cur_sp), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .status(status),
        .new_ring(new_ring), .new_cs(new_cs), .new_ip(new_ip),
        .new_flags(new_flags), .new_ss(new_ss), .new_sp(new_sp)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", what, act, expv);
        end
    endtask

    // table memory: data one cycle after the strobe
    always @(posedge clk) begin
        if (rd_en) begin
            if (rd_addr >= GB) rd_data <= gate_tab[8'((rd_addr - GB) >> 3)];
            else               rd_data <= stk_tab[2'((rd_addr - SB) >> 3)];
        end
    end

    // monitor: drives ready and scores reads, writes and results
    always @(negedge clk) begin
        if (!rst) begin
            rdy_ctr++;
            wr_ready = rdy_pat[rdy_ctr % 8];
            if (rd_en) begin
                if (exp_rd.size() == 0) chk(0, "R2/R6 unexpected table read", {32'h0, rd_addr}, 64'h0);
                else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_addr == e, "R2/R6 read address", {32'h0, rd_addr}, {32'h0, e});
                end
            end
            if (wr_valid && wr_ready) begin
                if (exp_wr.size() == 0) chk(0, "R3/R4 unexpected stack write", {wr_addr, wr_data}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_addr, wr_data} == e, "R5/R6/R7/R8 push addr,data", {wr_addr, wr_data}, e);
                end
            end
            if (done) begin
                n_done++;
                if (exp_res.size() == 0) chk(0, "R1 unexpected done", 64'h1, 64'h0);
                else begin
                    result_t e;
                    e = exp_res.pop_front();
                    chk(status == e.st, "R3/R4/R9 status", {62'h0, status}, {62'h0, e.st});
                    if (e.st == 2'd0) begin
                        chk(new_ring == e.ring, "R9 new ring", {62'h0, new_ring}, {62'h0, e.ring});
                        chk(new_cs == e.cs, "R9 new cs", {48'h0, new_cs}, {48'h0, e.cs});
                        chk(new_ip == e.ip, "R9 new ip", {32'h0, new_ip}, {32'h0, e.ip});
                        chk(new_flags == e.flags, "R10 new flags", {32'h0, new_flags}, {32'h0, e.flags});
                        chk(new_ss == e.ss, "R9 new ss", {48'h0, new_ss}, {48'h0, e.ss});
                        chk(new_sp == e.sp, "R9 new sp", {32'h0, new_sp}, {32'h0, e.sp});
                    end
                end
            end
        end
    end

    function automatic logic [63:0] mk_gate(input logic [15:0] sel, input logic [31:0] off, input logic [3:0] t);
        return {off[31:16], 1'b1, 2'b00, 1'b0, t, 8'h00, sel, off[15:0]};
    endfunction

    // driver: builds the expected items, then raises the request
    task automatic run(input logic [7:0] vec, input logic he, input logic [31:0] err,
                       input logic [1:0] ring, input logic [15:0] cs, input logic [31:0] ip,
                       input logic [31:0] fl, input logic [15:0] ss, input logic [31:0] sp,
                       input bit hold);
        logic [63:0] g;
        logic [3:0]  t;
        logic [1:0]  tr;
        logic [31:0] s;
        logic [15:0] nss;
        result_t     r;
        int          prev;
        g  = gate_tab[vec];
        t  = g[43:40];
        tr = g[17:16];
        r  = '0;
        if (t == 4'hE || t == 4'hF) r.st = (tr > ring) ? 2'd2 : 2'd0;
        else if (t == 4'h5)             r.st = 2'd1;
        else if (t == 4'h6 || t == 4'h7) r.st = 2'd3;
        else                            r.st = 2'd2;
        exp_rd.push_back(GB + {21'h0, vec, 3'b000});
        if (r.st == 2'd0) begin
            s = sp; nss = ss;
            if (tr < ring) begin
                exp_rd.push_back(SB + {27'h0, tr, 3'b000});
                s = stk_tab[tr][31:0]; nss = stk_tab[tr][47:32];
                s -= 4; exp_wr.push_back({s, 16'h0, ss});
                s -= 4; exp_wr.push_back({s, sp});
            end
            s -= 4; exp_wr.push_back({s, fl});
            s -= 4; exp_wr.push_back({s, 16'h0, cs});
            s -= 4; exp_wr.push_back({s, ip});
            if (he) begin s -= 4; exp_wr.push_back({s, err}); end
            r.ring = tr; r.cs = g[31:16]; r.ip = {g[63:48], g[15:0]};
            r.flags = (t == 4'hE) ? (fl & ~32'h200) : fl;
            r.ss = nss; r.sp = s;
        end
        exp_res.push_back(r);
        @(negedge clk);
        while (busy) @(negedge clk);
        prev = n_done;
        req_vector = vec; req_has_err = he; req_err = err; cur_ring = ring;
        cur_cs = cs; cur_ip = ip; cur_flags = fl; cur_ss = ss; cur_sp = sp;
        req_valid = 1'b1;
        @(negedge clk);
        if (hold) req_vector = vec + 8'd1;
        else      req_valid = 1'b0;
        wait (n_done == prev + 1);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(n_done == prev + 1, "R1 one result per request", 64'(n_done - prev), 64'h1);
        chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R3/R8 all expected traffic seen",
            64'(exp_wr.size() + exp_rd.size()), 64'h0);
        chk(!busy, "R1 idle after done", {63'h0, busy}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL R9 watchdog: done not reached actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) gate_tab[i] = 64'h0;
        stk_tab[0] = {16'h0, 16'h0010, 32'h0000_9000};
        stk_tab[1] = {16'h0, 16'h0021, 32'h0000_7000};
        stk_tab[2] = {16'h0, 16'h0032, 32'h0000_6000};
        stk_tab[3] = 64'h0;
        gate_tab[8'h20] = mk_gate(16'h0008, 32'h8014_5034, 4'hE);
        gate_tab[8'h2E] = mk_gate(16'h0008, 32'h8014_6188, 4'hF);
        gate_tab[8'h41] = mk_gate(16'h0009, 32'h1234_ABCD, 4'hE);
        gate_tab[8'h02] = mk_gate(16'h0058, 32'h0000_0000, 4'h5);
        gate_tab[8'h03] = mk_gate(16'h0008, 32'h0000_1111, 4'h0);
        gate_tab[8'h04] = mk_gate(16'h0008, 32'h0000_2222, 4'h6);
        gate_tab[8'h05] = mk_gate(16'h000B, 32'h0000_3333, 4'hF);
        gate_tab[8'h06] = mk_gate(16'h000A, 32'hCAFE_0000, 4'hF);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !wr_valid && !rd_en, "R1 reset state",
            {60'h0, busy, done, wr_valid, rd_en}, 64'h0);

        // R5 R10: same-ring interrupt gate, no error code
        run(8'h20, 1'b0, 32'h0, 2'd0, 16'h0008, 32'h8000_1000, 32'h0000_0246, 16'h0010, 32'h0000_A000, 0);
        // R6 R7 R10: ring 3 to 0 through a trap gate with an error code, stalled writes
        rdy_pat = 8'b1011_0110;
        run(8'h2E, 1'b1, 32'h0000_0ACE, 2'd3, 16'h001B, 32'h0040_1234, 32'h0000_0202, 16'h0023, 32'h0012_FF00, 0);
        // R6: ring 3 to 1 through an interrupt gate
        rdy_pat = 8'b0101_1111;
        run(8'h41, 1'b0, 32'h0, 2'd3, 16'h001B, 32'h0040_5678, 32'h0000_0A03, 16'h0023, 32'h0011_0000, 0);
        // R3: task gate, bad type, 16-bit gate
        run(8'h02, 1'b1, 32'h5, 2'd3, 16'h001B, 32'h1, 32'h202, 16'h0023, 32'h8000, 0);
        run(8'h03, 1'b0, 32'h0, 2'd0, 16'h0008, 32'h1, 32'h202, 16'h0010, 32'h8000, 0);
        run(8'h04, 1'b0, 32'h0, 2'd0, 16'h0008, 32'h1, 32'h202, 16'h0010, 32'h8000, 0);
        // R4: gate targets ring 3 from ring 0
        run(8'h05, 1'b0, 32'h0, 2'd0, 16'h0008, 32'h1, 32'h202, 16'h0010, 32'h8000, 0);
        // R1: request held high through the whole entry, vector changed meanwhile
        rdy_pat = 8'b1110_1101;
        run(8'h06, 1'b1, 32'h0000_00E1, 2'd3, 16'h001B, 32'h0040_9999, 32'h0000_0246, 16'h0023, 32'h0013_0000, 1);
        // R8: back-to-back pushes with ready always high, error code on same ring
        rdy_pat = 8'hFF;
        run(8'h2E, 1'b1, 32'h0000_0011, 2'd0, 16'h0008, 32'h8001_0000, 32'h0000_0002, 16'h0010, 32'h0000_C000, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule